// File: doc/BRIEF.md
# Column Data Timing Unit

This block is the column-side data engine of a packetized DRAM device. It decodes column command packets. A read takes a 16-byte snapshot of the addressed word from a small internal array and drives it on two 72-bit output groups a programmed number of cycles later. A write samples a 16-byte data packet a fixed number of cycles after its command and holds that packet in a staging buffer. The staged data is committed to the array only when a mask-or-extended control packet arrives in the retire slot. That slot lies a fixed number of cycles after the write command.

The control packet in the retire slot carries a mode bit. With the bit clear, every byte of the staged write is committed. With the bit set, two 8-bit mask fields choose which bytes are committed and which keep their old contents. The read latency comes from a timing-parameter write port. Reads may be issued every cycle, so several reads can be in flight at once.

Top module: `col_data_unit`

## Requirements
- R1: After reset, `qValid` is low, both output groups are zero, the read latency is 8 and every array word reads back as zero.
- R2: A read command (`colCmd` = 2'b01) sampled at clock edge n drives `qValid` high for exactly one cycle after edge n+L, where L is the current read latency (8 to 12).
- R3: A pulse on `cfgWe` loads `cfgReadLat` into the read latency only when the value lies in 8..12. Any other value leaves the latency unchanged.
- R4: Reads may be issued on consecutive cycles. Each returns its own data in issue order, L cycles after its command.
- R5: A write command (`colCmd` = 2'b10) sampled at edge n captures `dInA`/`dInB` at edge n+WR_LAT. Byte i of group A is bits [9i+7:9i] and byte i of group B is bits [9i+7:9i] of `dInB`. Bit 9i+8 of each group is ignored.
- R6: A control packet (`mxValid` = 1) sampled at edge n+MASK_GAP retires the write from edge n. With `mxMaskBit` = 0, all 16 bytes are committed.
- R7: With `mxMaskBit` = 1 in the retire slot, bit i of `mxMaskA` commits byte i of group A when 1 and leaves it unchanged when 0. `mxMaskB` does the same for group B.
- R8: A control packet outside any retire slot changes nothing. A write whose retire slot holds no control packet is never committed.
- R9: A commit at edge m is visible to reads sampled at edges after m only. A read sampled at or before the commit edge returns the earlier contents.
- R10: Bit 9i+8 of both output groups is always zero, and both groups are zero whenever `qValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Timing-parameter write strobe |
| cfgReadLat | input | 4 | Requested read latency in cycles |
| colCmd | input | 2 | Column command: 00 none, 01 read, 10 write, 11 none |
| colAddr | input | ADDR_W | Column word address |
| mxValid | input | 1 | Mask-or-extended control packet present |
| mxMaskBit | input | 1 | 1 selects a byte-masked commit, 0 an unconditional commit |
| mxMaskA | input | 8 | Byte enables for group A |
| mxMaskB | input | 8 | Byte enables for group B |
| dInA | input | 72 | Write data group A, eight 9-bit bytes |
| dInB | input | 72 | Write data group B, eight 9-bit bytes |
| qValid | output | 1 | Read data valid |
| qOutA | output | 72 | Read data group A |
| qOutB | output | 72 | Read data group B |

## Verification
Read data is due exactly L cycles after the edge that samples the read, with L taken from the latency in force at that edge. Write data must be on the inputs WR_LAT cycles after the write command. The retire packet must arrive MASK_GAP cycles after it. The bench schedules every input per target edge and keeps a model array that it updates at the retire edge, after it has served any read at that same edge. Each expected read item carries its due cycle, and the monitor compares at that cycle only. On every other cycle the monitor requires idle, all-zero outputs, so both an early and a late result fail.

// File: rtl/col_timing_pkg.sv
`timescale 1ns/1ps
package col_timing_pkg;
  localparam int GRP_BYTES = 8;
  localparam int PIN_W     = 9;
  localparam int BYTE_W    = 8;
  localparam int GRP_W     = GRP_BYTES * PIN_W;
  localparam int WORD_BYTES = 2 * GRP_BYTES;
  localparam int WORD_W    = WORD_BYTES * BYTE_W;
  localparam int LAT_MIN   = 8;
  localparam int LAT_MAX   = 12;
  localparam int LAT_W     = $clog2(LAT_MAX + 1);

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } colCmd_e;

  typedef struct packed {
    logic             rdLaunch;
    logic             dataCapture;
    logic             commit;
    logic             commitMasked;
    logic             qFire;
    logic [LAT_W-1:0] qTap;
  } colStrobe_t;
endpackage

// File: rtl/col_ctrl.sv
`timescale 1ns/1ps
module col_ctrl
  import col_timing_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int WR_LAT   = 6,
  parameter int MASK_GAP = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [LAT_W-1:0]  cfgReadLat,
  input  logic [1:0]        colCmd,
  input  logic [ADDR_W-1:0] colAddr,
  input  logic              mxValid,
  input  logic              mxMaskBit,
  output colStrobe_t        stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] commitAddr,
  output logic              qValid
);
  localparam logic [LAT_W-1:0] LAT_LO = LAT_W'(LAT_MIN);
  localparam logic [LAT_W-1:0] LAT_HI = LAT_W'(LAT_MAX);

  logic [LAT_W-1:0]   rdLat;
  logic [LAT_W-1:0]   rdTap;
  logic [LAT_MAX-1:0] rdV;
  logic [MASK_GAP-1:0] wrV;
  logic [ADDR_W-1:0]  wrA [MASK_GAP];
  logic               isRead;
  logic               isWrite;
  logic               latOk;

  assign isRead  = (colCmd == CMD_READ);
  assign isWrite = (colCmd == CMD_WRITE);
  assign latOk   = (cfgReadLat >= LAT_LO) && (cfgReadLat <= LAT_HI);
  assign rdTap   = rdLat - LAT_W'(1);

  // timing-parameter register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdLat <= LAT_LO;
    else if (cfgWe && latOk) rdLat <= cfgReadLat;
  end

  // read tracking: one bit per cycle of age, tap chosen by latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdV    <= '0;
      qValid <= 1'b0;
    end else begin
      rdV    <= {rdV[LAT_MAX-2:0], isRead};
      qValid <= rdV[rdTap];
    end
  end

  // write tracking: address travels with a valid bit until its retire slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrV <= '0;
      for (int i = 0; i < MASK_GAP; i++) wrA[i] <= '0;
    end else begin
      wrV    <= {wrV[MASK_GAP-2:0], isWrite};
      wrA[0] <= colAddr;
      for (int i = 1; i < MASK_GAP; i++) wrA[i] <= wrA[i-1];
    end
  end

  assign stb.rdLaunch     = isRead;
  assign stb.dataCapture  = wrV[WR_LAT-1];
  assign stb.commit       = wrV[MASK_GAP-1] && mxValid;
  assign stb.commitMasked = mxMaskBit;
  assign stb.qFire        = rdV[rdTap];
  assign stb.qTap         = rdTap;
  assign rdAddr           = colAddr;
  assign commitAddr       = wrA[MASK_GAP-1];

  AST_LAT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rdLat >= LAT_LO) && (rdLat <= LAT_HI)); // R3
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(rdLat)); // R3
  AST_BAD_LAT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !latOk) |=> $stable(rdLat)); // R3
endmodule

// File: rtl/col_datapath.sv
`timescale 1ns/1ps
module col_datapath
  import col_timing_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int HOLD   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  colStrobe_t        stb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] commitAddr,
  input  logic [GRP_W-1:0]  dInA,
  input  logic [GRP_W-1:0]  dInB,
  input  logic [GRP_BYTES-1:0] maskA,
  input  logic [GRP_BYTES-1:0] maskB,
  output logic [GRP_W-1:0]  qOutA,
  output logic [GRP_W-1:0]  qOutB
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int B_BASE = GRP_BYTES * BYTE_W;

  logic [WORD_W-1:0] mem    [DEPTH];
  logic [WORD_W-1:0] rdPipe [LAT_MAX];
  logic [WORD_W-1:0] wdPipe [HOLD];
  logic [WORD_W-1:0] qWord;
  logic [WORD_W-1:0] inWord;
  logic [WORD_W-1:0] oldWord;
  logic [WORD_W-1:0] mergedWord;
  logic [WORD_W-1:0] stagedWord;
  logic [WORD_BYTES-1:0] byteEn;

  assign oldWord    = mem[commitAddr];
  assign stagedWord = wdPipe[HOLD-1];
  assign byteEn     = stb.commitMasked ? {maskB, maskA} : '1;

  // strip the ninth pin on the way in, zero it on the way out
  for (genvar b = 0; b < GRP_BYTES; b++) begin : g_lane
    assign inWord[b*BYTE_W +: BYTE_W]          = dInA[b*PIN_W +: BYTE_W];
    assign inWord[B_BASE + b*BYTE_W +: BYTE_W] = dInB[b*PIN_W +: BYTE_W];
    assign qOutA[b*PIN_W +: PIN_W] = {1'b0, qWord[b*BYTE_W +: BYTE_W]};
    assign qOutB[b*PIN_W +: PIN_W] = {1'b0, qWord[B_BASE + b*BYTE_W +: BYTE_W]};
  end

  // byte merge of staged data over the current array word
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_merge
    assign mergedWord[k*BYTE_W +: BYTE_W] =
      byteEn[k] ? stagedWord[k*BYTE_W +: BYTE_W] : oldWord[k*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < DEPTH; r++)   mem[r]    <= '0;
      for (int i = 0; i < LAT_MAX; i++) rdPipe[i] <= '0;
      for (int i = 0; i < HOLD; i++)    wdPipe[i] <= '0;
      qWord <= '0;
    end else begin
      if (stb.commit) mem[commitAddr] <= mergedWord;
      rdPipe[0] <= stb.rdLaunch ? mem[rdAddr] : '0;
      for (int i = 1; i < LAT_MAX; i++) rdPipe[i] <= rdPipe[i-1];
      wdPipe[0] <= stb.dataCapture ? inWord : '0;
      for (int i = 1; i < HOLD; i++) wdPipe[i] <= wdPipe[i-1];
      qWord <= stb.qFire ? rdPipe[stb.qTap] : '0;
    end
  end

  for (genvar r = 0; r < DEPTH; r++) begin : g_rowChk
    AST_ROW_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
      !(stb.commit && (commitAddr == ADDR_W'(r))) |=> $stable(mem[r])); // R8
  end
  AST_QWORD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.qFire |=> (qWord == '0)); // R10
endmodule

// File: rtl/col_data_unit.sv
`timescale 1ns/1ps
module col_data_unit
  import col_timing_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int WR_LAT   = 6,
  parameter int MASK_GAP = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [3:0]        cfgReadLat,
  input  logic [1:0]        colCmd,
  input  logic [ADDR_W-1:0] colAddr,
  input  logic              mxValid,
  input  logic              mxMaskBit,
  input  logic [7:0]        mxMaskA,
  input  logic [7:0]        mxMaskB,
  input  logic [71:0]       dInA,
  input  logic [71:0]       dInB,
  output logic              qValid,
  output logic [71:0]       qOutA,
  output logic [71:0]       qOutB
);
  localparam int HOLD = MASK_GAP - WR_LAT;

  colStrobe_t        stb;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] commitAddr;

  col_ctrl #(.ADDR_W(ADDR_W), .WR_LAT(WR_LAT), .MASK_GAP(MASK_GAP)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgReadLat(cfgReadLat),
    .colCmd(colCmd), .colAddr(colAddr), .mxValid(mxValid), .mxMaskBit(mxMaskBit),
    .stb(stb), .rdAddr(rdAddr), .commitAddr(commitAddr), .qValid(qValid)
  );

  col_datapath #(.ADDR_W(ADDR_W), .HOLD(HOLD)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .commitAddr(commitAddr),
    .dInA(dInA), .dInB(dInB), .maskA(mxMaskA), .maskB(mxMaskB),
    .qOutA(qOutA), .qOutB(qOutB)
  );

  AST_Q_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !qValid |-> (qOutA == '0) && (qOutB == '0)); // R10
  for (genvar b = 0; b < GRP_BYTES; b++) begin : g_ninthChk
    AST_NINTH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (qOutA[b*PIN_W + BYTE_W] == 1'b0) && (qOutB[b*PIN_W + BYTE_W] == 1'b0)); // R10
  end
endmodule

// File: tb/col_data_unit_tb_top.sv
`timescale 1ns/1ps
module col_data_unit_tb_top;
  localparam int WR_LAT   = 6;
  localparam int MASK_GAP = 8;
  localparam int END_CYC  = 180;
  localparam int WDOG     = 5000;
  localparam logic [71:0] JUNK = {8{9'h1AB}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [3:0] cfgReadLat = '0;
  logic [1:0] colCmd = '0;
  logic [3:0] colAddr = '0;
  logic mxValid = 1'b0, mxMaskBit = 1'b0;
  logic [7:0] mxMaskA = '0, mxMaskB = '0;
  logic [71:0] dInA = JUNK, dInB = JUNK;
  logic qValid;
  logic [71:0] qOutA, qOutB;

  always #4 clk = ~clk;

  col_data_unit #(.ADDR_W(4), .WR_LAT(WR_LAT), .MASK_GAP(MASK_GAP)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgReadLat(cfgReadLat),
    .colCmd(colCmd), .colAddr(colAddr), .mxValid(mxValid), .mxMaskBit(mxMaskBit),
    .mxMaskA(mxMaskA), .mxMaskB(mxMaskB), .dInA(dInA), .dInB(dInB),
    .qValid(qValid), .qOutA(qOutA), .qOutB(qOutB)
  );

  typedef struct {
    logic [1:0] cmd; logic [3:0] addr; string tag;
    bit hasData; logic [71:0] dA; logic [71:0] dB;
    bit hasMask; bit mBit; logic [7:0] ma; logic [7:0] mb;
    bit hasCfg; logic [3:0] cfgVal;
  } op_t;
  typedef struct { int due; logic [71:0] a; logic [71:0] b; string tag; } exp_t;

  op_t ops [int];
  exp_t sbq [$];
  logic [127:0] model [16];
  int benchLat = 8;
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic op_t blankOp();
    op_t o;
    o.cmd = 2'b00; o.addr = '0; o.tag = "";
    o.hasData = 0; o.dA = JUNK; o.dB = JUNK;
    o.hasMask = 0; o.mBit = 0; o.ma = '0; o.mb = '0;
    o.hasCfg = 0; o.cfgVal = '0;
    return o;
  endfunction

  function automatic logic [71:0] mkGrp(logic [7:0] seed);
    logic [71:0] g;
    for (int i = 0; i < 8; i++) g[9*i +: 9] = {1'b1, seed + 8'(i * 29)};
    return g;
  endfunction

  function automatic logic [127:0] packW(logic [71:0] a, logic [71:0] b);
    logic [127:0] w;
    for (int i = 0; i < 8; i++) begin
      w[8*i +: 8]      = a[9*i +: 8];
      w[64 + 8*i +: 8] = b[9*i +: 8];
    end
    return w;
  endfunction

  function automatic logic [71:0] outGrp(logic [63:0] h);
    logic [71:0] g;
    for (int i = 0; i < 8; i++) g[9*i +: 9] = {1'b0, h[8*i +: 8]};
    return g;
  endfunction

  task automatic touch(int t);
    if (!ops.exists(t)) ops[t] = blankOp();
  endtask

  task automatic schedRead(int t, logic [3:0] a, string tag);
    touch(t); ops[t].cmd = 2'b01; ops[t].addr = a; ops[t].tag = tag;
  endtask

  task automatic schedMask(int t, bit m, logic [7:0] ma, logic [7:0] mb);
    touch(t); ops[t].hasMask = 1; ops[t].mBit = m; ops[t].ma = ma; ops[t].mb = mb;
  endtask

  // mode: 0 no retire packet, 1 unconditional, 2 byte-masked
  task automatic schedWrite(int t, logic [3:0] a, logic [71:0] da, logic [71:0] db,
                            int mode, logic [7:0] ma, logic [7:0] mb);
    touch(t); ops[t].cmd = 2'b10; ops[t].addr = a;
    touch(t + WR_LAT); ops[t+WR_LAT].hasData = 1;
    ops[t+WR_LAT].dA = da; ops[t+WR_LAT].dB = db;
    if (mode != 0) schedMask(t + MASK_GAP, mode == 2, ma, mb);
  endtask

  task automatic schedCfg(int t, logic [3:0] v);
    touch(t); ops[t].hasCfg = 1; ops[t].cfgVal = v;
  endtask

  task automatic check(bit ok, string tag, logic v, logic [71:0] a, logic [71:0] b,
                       logic ev, logic [71:0] ea, logic [71:0] eb);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cyc=%0d actual v=%0b a=%h b=%h expected v=%0b a=%h b=%h",
               tag, cyc, v, a, b, ev, ea, eb);
    end
  endtask

  // monitor then driver, one process at each falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        exp_t e;
        e = sbq.pop_front();
        check(qValid === 1'b1 && qOutA === e.a && qOutB === e.b, e.tag,
              qValid, qOutA, qOutB, 1'b1, e.a, e.b);
      end else begin
        check(qValid === 1'b0 && qOutA === '0 && qOutB === '0, "R10 idle",
              qValid, qOutA, qOutB, 1'b0, '0, '0);
      end
    end
    begin
      int t;
      op_t o;
      t = cyc + 1;
      o = ops.exists(t) ? ops[t] : blankOp();
      colCmd = o.cmd; colAddr = o.addr;
      dInA = o.dA; dInB = o.dB;
      mxValid = o.hasMask; mxMaskBit = o.mBit; mxMaskA = o.ma; mxMaskB = o.mb;
      cfgWe = o.hasCfg; cfgReadLat = o.cfgVal;
      if (o.cmd == 2'b01) begin
        exp_t e;
        e.due = t + benchLat;
        e.a = outGrp(model[o.addr][63:0]);
        e.b = outGrp(model[o.addr][127:64]);
        e.tag = o.tag;
        sbq.push_back(e);
      end
      if (o.hasCfg && o.cfgVal >= 4'd8 && o.cfgVal <= 4'd12) benchLat = int'(o.cfgVal);
      if (o.hasMask && ops.exists(t - MASK_GAP) && ops[t-MASK_GAP].cmd == 2'b10) begin
        logic [127:0] nw;
        logic [15:0] en;
        op_t w;
        w = ops[t-MASK_GAP];
        nw = packW(ops[t-MASK_GAP+WR_LAT].dA, ops[t-MASK_GAP+WR_LAT].dB);
        en = o.mBit ? {o.mb, o.ma} : 16'hFFFF;
        for (int k = 0; k < 16; k++)
          if (en[k]) model[w.addr][8*k +: 8] = nw[8*k +: 8];
      end
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) model[r] = '0;
    // R1, R2: first read at reset latency, reset array contents
    schedRead(20, 4'd3, "R1 reset array R2 latency");
    // R5, R6: unconditional commit, ninth pins set on input
    schedWrite(22, 4'd1, mkGrp(8'h10), mkGrp(8'h90), 1, 8'h00, 8'h00);
    schedRead(30, 4'd1, "R9 read at commit edge");
    schedRead(31, 4'd1, "R6 unconditional commit");
    schedRead(32, 4'd3, "R4 back-to-back");
    // R7: byte-masked commit
    schedWrite(40, 4'd1, mkGrp(8'h33), mkGrp(8'hC1), 2, 8'hA5, 8'h3C);
    schedRead(49, 4'd1, "R7 masked commit");
    // R8: write with empty retire slot, stray packets
    schedWrite(60, 4'd2, mkGrp(8'h44), mkGrp(8'h55), 0, 8'h00, 8'h00);
    schedMask(65, 1'b0, 8'h00, 8'h00);
    schedMask(66, 1'b1, 8'hFF, 8'hFF);
    schedRead(70, 4'd2, "R8 dropped write");
    schedRead(71, 4'd1, "R8 stray packets");
    // R3: latency programming
    schedCfg(80, 4'd13);
    schedRead(82, 4'd1, "R3 out-of-range ignored");
    schedCfg(95, 4'd12);
    schedRead(97, 4'd1, "R2 latency 12");
    schedCfg(115, 4'd5);
    schedRead(117, 4'd3, "R3 low value ignored");
    schedCfg(135, 4'd10);
    schedWrite(140, 4'd5, mkGrp(8'h61), mkGrp(8'h72), 1, 8'h00, 8'h00);
    schedWrite(141, 4'd6, mkGrp(8'h83), mkGrp(8'h94), 1, 8'h00, 8'h00);
    schedRead(148, 4'd6, "R9 pending write");
    schedRead(150, 4'd5, "R4 overlap lat 10");
    schedRead(151, 4'd6, "R5 back-to-back writes");
    schedRead(152, 4'd1, "R4 overlap lat 10");

    repeat (10) @(negedge clk);
    rstN = 1'b1;
    while (cyc < 15) @(negedge clk);
    check(qValid === 1'b0 && qOutA === '0 && qOutB === '0, "R1 reset outputs",
          qValid, qOutA, qOutB, 1'b0, '0, '0);
    while (cyc < END_CYC) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL R2 pending reads actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule